// File: doc/BRIEF.md
# Full-Rate Stream Width Adapter

This block moves a ready/valid stream from one data width to another when the larger width is a whole multiple of the smaller one. If the input is wider, each accepted word is cut into sub-words that leave one after another on the narrow output. If the output is wider, consecutive narrow inputs are collected into one wide word. A parameter chooses whether the low-order or the high-order sub-word comes first in time. When the two widths are equal, the block becomes a single-register stage with the same handshake.

The narrow side runs at one transfer per clock without idle cycles, as long as the far side keeps up. A splitter followed by a packer with swapped widths and the same ordering returns the original stream unchanged, delayed by a few cycles. The block is meant to sit between a wide bus and a narrow link inside a larger datapath.

Top module: `stream_width_adapter`

## Requirements
- R1: A word moves across a port only in a cycle where that port's valid and ready are both high; a word offered while ready is low is left on the input and taken later, unchanged.
- R2: With LSB-first ordering and a wider input, the sub-word in bits [OUT_W-1:0] of each input word leaves first, followed by the next higher slices in rising order.
- R3: With MSB-first ordering, the highest slice of a wide word is the first narrow word in time, for both splitting and packing.
- R4: With LSB-first ordering and a wider output, the first accepted narrow word of a group lands in bits [IN_W-1:0] of the packed word, and later ones fill the higher slices.
- R5: When packing, in_ready is high in every cycle where out_ready is high.
- R6: When packing, the packed word is valid in the cycle after its last sub-word is accepted. A packed word waiting at the output does not stop the first sub-word of the next group from being accepted.
- R7: When splitting with an input that is always valid and an output that is always ready, out_valid stays high in every cycle from the first output until the last sub-word of the last word. The next wide word is loaded in the same cycle that the final sub-word of the current word leaves.
- R8: While out_valid is high and out_ready is low, out_valid and out_data keep their values on the next cycle.
- R9: An active-high synchronous reset clears all valid state and the sub-word position. out_valid is low in the cycle after any clock edge where reset was high.
- R10: With equal widths, an accepted word appears on the output in the next cycle. A word held at the output with out_ready low blocks the input.
- R11: A splitter from W to a narrower width followed by a packer back to W, with the same ordering, delivers exactly the sequence of words given to the splitter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take the input word |
| in_data | input | IN_W | Input word |
| out_valid | output | 1 | Output word is offered |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | OUT_W | Output word |

## Verification
When packing, a group can complete in the same cycle that the previous packed word is taken. When splitting, the last sub-word of a word can leave in the same cycle that the next wide word is loaded. The bench forces the packing case by holding out_ready low until the next group's final sub-word is waiting, then raising it. It checks that in_ready goes high in that cycle and that the new word is presented on the next cycle. The splitting case is forced with a source and sink that are both always active, and it is judged by counting out_valid cycles against the expected unbroken run. A queue model compares every delivered word in both cases.

// File: rtl/swa_pkg.sv
`timescale 1ns/1ps
package swa_pkg;

    typedef enum logic {
        ORD_LSB_FIRST = 1'b0,
        ORD_MSB_FIRST = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'd0,
        MODE_SPLIT = 2'd1,
        MODE_PACK  = 2'd2
    } mode_e;

    function automatic int ratio_of(input int a, input int b);
        return (a > b) ? (a / b) : (b / a);
    endfunction

    function automatic int cnt_w(input int r);
        return (r > 1) ? $clog2(r) : 1;
    endfunction

    function automatic mode_e mode_of(input int iw, input int ow);
        if (iw > ow)      return MODE_SPLIT;
        else if (iw < ow) return MODE_PACK;
        else              return MODE_PASS;
    endfunction

endpackage

// File: rtl/swa_split.sv
`timescale 1ns/1ps
module swa_split #(
    parameter int              IN_W  = 16,
    parameter int              OUT_W = 4,
    parameter swa_pkg::order_e ORDER = swa_pkg::ORD_LSB_FIRST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);
    localparam int      R    = swa_pkg::ratio_of(IN_W, OUT_W);
    localparam int      CW   = swa_pkg::cnt_w(R);
    localparam bit      MSBF = (ORDER == swa_pkg::ORD_MSB_FIRST);
    localparam [CW-1:0] LAST = CW'(R - 1);

    logic [IN_W-1:0]  word_q;
    logic             busy_q;
    logic [CW-1:0]    idx_q;
    logic [CW-1:0]    slot;
    logic             at_last;
    logic             out_fire;
    logic             in_fire;
    logic [OUT_W-1:0] parts [R];

    for (genvar g = 0; g < R; g++) begin : g_slice
        assign parts[g] = word_q[g*OUT_W +: OUT_W];
    end

    assign at_last   = (idx_q == LAST);
    assign slot      = MSBF ? (LAST - idx_q) : idx_q;
    assign out_valid = busy_q;
    assign out_data  = parts[slot];
    assign out_fire  = busy_q && out_ready;
    assign in_ready  = !busy_q || (out_ready && at_last);
    assign in_fire   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            word_q <= '0;
        end else begin
            if (out_fire) begin
                idx_q <= at_last ? '0 : idx_q + 1'b1;
            end
            if (in_fire) begin
                word_q <= in_data;
                busy_q <= 1'b1;
            end else if (out_fire && at_last) begin
                busy_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/swa_pack.sv
`timescale 1ns/1ps
module swa_pack #(
    parameter int              IN_W  = 4,
    parameter int              OUT_W = 16,
    parameter swa_pkg::order_e ORDER = swa_pkg::ORD_LSB_FIRST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);
    localparam int      R    = swa_pkg::ratio_of(IN_W, OUT_W);
    localparam int      CW   = swa_pkg::cnt_w(R);
    localparam bit      MSBF = (ORDER == swa_pkg::ORD_MSB_FIRST);
    localparam [CW-1:0] LAST = CW'(R - 1);

    logic [OUT_W-1:0] acc_q;
    logic [OUT_W-1:0] obuf_q;
    logic             ov_q;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    slot;
    logic             at_last;
    logic             in_fire;
    logic [OUT_W-1:0] merged;

    assign at_last = (cnt_q == LAST);
    assign slot    = MSBF ? (LAST - cnt_q) : cnt_q;

    for (genvar g = 0; g < R; g++) begin : g_lane
        assign merged[g*IN_W +: IN_W] =
            (slot == CW'(g)) ? in_data : acc_q[g*IN_W +: IN_W];
    end

    assign in_ready  = !at_last || !ov_q || out_ready;
    assign in_fire   = in_valid && in_ready;
    assign out_valid = ov_q;
    assign out_data  = obuf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            obuf_q <= '0;
            ov_q   <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (in_fire) begin
                acc_q <= merged;
                cnt_q <= at_last ? '0 : cnt_q + 1'b1;
            end
            if (in_fire && at_last) begin
                obuf_q <= merged;
                ov_q   <= 1'b1;
            end else if (ov_q && out_ready) begin
                ov_q   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/swa_pass.sv
`timescale 1ns/1ps
module swa_pass #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    logic [W-1:0] data_q;
    logic         v_q;

    assign in_ready  = !v_q || out_ready;
    assign out_valid = v_q;
    assign out_data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q    <= 1'b0;
            data_q <= '0;
        end else if (in_valid && in_ready) begin
            v_q    <= 1'b1;
            data_q <= in_data;
        end else if (out_ready) begin
            v_q    <= 1'b0;
        end
    end
endmodule

// File: rtl/stream_width_adapter.sv
`timescale 1ns/1ps
module stream_width_adapter #(
    parameter int              IN_W  = 16,
    parameter int              OUT_W = 4,
    parameter swa_pkg::order_e ORDER = swa_pkg::ORD_LSB_FIRST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);
    localparam swa_pkg::mode_e MODE = swa_pkg::mode_of(IN_W, OUT_W);

    if (MODE == swa_pkg::MODE_SPLIT) begin : g_split
        swa_split #(.IN_W(IN_W), .OUT_W(OUT_W), .ORDER(ORDER)) u_core (
            .clk(clk), .rst(rst),
            .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
            .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
        );
    end else if (MODE == swa_pkg::MODE_PACK) begin : g_pack
        swa_pack #(.IN_W(IN_W), .OUT_W(OUT_W), .ORDER(ORDER)) u_core (
            .clk(clk), .rst(rst),
            .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
            .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
        );
    end else begin : g_pass
        swa_pass #(.W(IN_W)) u_core (
            .clk(clk), .rst(rst),
            .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
            .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
        );
    end
endmodule

// File: rtl/swa_checker.sv
`timescale 1ns/1ps
module swa_checker #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [IN_W-1:0]  in_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data
);
    localparam int R  = swa_pkg::ratio_of(IN_W, OUT_W);
    localparam int CW = swa_pkg::cnt_w(R);

    initial begin
        assert_width_multiple_R1: assert ((IN_W > OUT_W) ? (IN_W % OUT_W == 0) : (OUT_W % IN_W == 0));
    end

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(negedge clk) begin
        if (rst_q) begin
            assert_reset_idle_R9: assert (!out_valid);
        end
    end

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    if (IN_W < OUT_W) begin : g_pack_chk
        logic [CW-1:0] beat_q;
        always_ff @(posedge clk) begin
            if (rst) beat_q <= '0;
            else if (in_valid && in_ready)
                beat_q <= (beat_q == CW'(R - 1)) ? '0 : beat_q + 1'b1;
        end

        assert_up_never_blocks_R5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && out_ready) |-> in_ready);

        assert_pack_latency_R6: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready && beat_q == CW'(R - 1)) |=> out_valid);
    end else if (IN_W > OUT_W) begin : g_split_chk
        assert_down_no_gap_R7: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_ready && in_valid) |=> out_valid);

        assert_split_takes_when_empty_R1: assert property (@(posedge clk) disable iff (rst)
            !out_valid |-> in_ready);
    end else begin : g_pass_chk
        assert_pass_latency_R10: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
    end
endmodule

bind stream_width_adapter swa_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_stream_width_adapter.sv
`timescale 1ns/1ps
module tb_src #(parameter int W = 8) (
    input  logic         clk,
    input  logic         rst,
    input  int           vprob,
    input  logic         man_en,
    input  logic         man_valid,
    input  logic [W-1:0] man_data,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] data
);
    logic         rv = 1'b0;
    logic [W-1:0] rd = '0;
    assign valid = man_en ? man_valid : rv;
    assign data  = man_en ? man_data  : rd;
    initial begin
        forever begin
            bit fire;
            @(negedge clk);
            fire = rv && ready && !man_en;
            @(posedge clk);
            #1;
            if (rst) rv = 1'b0;
            else if (fire || !rv) begin
                rv = ($urandom_range(99) < vprob);
                rd = W'({$urandom(), $urandom()});
            end
        end
    end
endmodule

module tb_snk (
    input  logic clk,
    input  int   rprob,
    input  logic man_en,
    input  logic man_ready,
    output logic ready
);
    logic rr = 1'b0;
    assign ready = man_en ? man_ready : rr;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            rr = ($urandom_range(99) < rprob);
        end
    end
endmodule

module tb_scoreboard #(
    parameter int    IN_W  = 8,
    parameter int    OUT_W = 8,
    parameter bit    MSBF  = 0,
    parameter string REQ   = "R2"
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [IN_W-1:0]  in_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data
);
    localparam int R = (IN_W > OUT_W) ? IN_W / OUT_W : OUT_W / IN_W;
    logic [OUT_W-1:0] expq[$];
    logic [OUT_W-1:0] part = '0;
    logic [OUT_W-1:0] hold_d = '0;
    bit hold_v = 0;
    int beat = 0;
    int nchk = 0;
    int nfail = 0;
    int nout = 0;

    always @(negedge clk) begin
        if (rst) begin
            hold_v = 0;
            beat = 0;
            expq.delete();
        end else begin
            if (hold_v) begin
                nchk++;
                if (!(out_valid && out_data == hold_d)) begin
                    nfail++;
                    $display("FAIL R8 (%s lane) held output changed: actual v=%0b d=%0h expected v=1 d=%0h",
                             REQ, out_valid, out_data, hold_d);
                end
            end
            if (IN_W < OUT_W && in_valid && out_ready) begin
                nchk++;
                if (!in_ready) begin
                    nfail++;
                    $display("FAIL R5 (%s lane) packer blocked input: actual in_ready=0 expected 1", REQ);
                end
            end
            if (in_valid && in_ready) begin
                if (IN_W >= OUT_W) begin
                    for (int k = 0; k < R; k++) begin
                        int s;
                        s = MSBF ? (R - 1 - k) : k;
                        expq.push_back(OUT_W'(in_data >> (s * OUT_W)));
                    end
                end else begin
                    int s;
                    logic [OUT_W-1:0] m;
                    logic [OUT_W-1:0] v;
                    s = MSBF ? (R - 1 - beat) : beat;
                    m = (OUT_W'(1) << IN_W) - 1'b1;
                    v = OUT_W'(in_data);
                    part = (part & ~(m << (s * IN_W))) | (v << (s * IN_W));
                    beat++;
                    if (beat == R) begin
                        expq.push_back(part);
                        beat = 0;
                    end
                end
            end
            if (out_valid && out_ready) begin
                nout++;
                nchk++;
                if (expq.size() == 0) begin
                    nfail++;
                    $display("FAIL %s unexpected output word: actual %0h expected none", REQ, out_data);
                end else begin
                    logic [OUT_W-1:0] e;
                    e = expq.pop_front();
                    if (out_data !== e) begin
                        nfail++;
                        $display("FAIL %s output word order: actual %0h expected %0h", REQ, out_data, e);
                    end
                end
            end
            hold_v = out_valid && !out_ready;
            hold_d = out_data;
        end
    end

    function automatic void final_check();
        nchk++;
        if (expq.size() != 0 || nout == 0) begin
            nfail++;
            $display("FAIL %s stream not fully delivered: actual pending=%0d delivered=%0d expected pending=0 delivered>0",
                     REQ, expq.size(), nout);
        end
    endfunction
endmodule

module sim_stream_width_adapter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int vp = 0;
    int rp = 100;
    logic man = 1'b1;
    int tchk = 0;
    int tfail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tchk++;
        if (!ok) begin
            tfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // lane 0: 16 -> 4, LSB first
    logic a0_iv, a0_ir, a0_ov, a0_or;
    logic [15:0] a0_id;
    logic [3:0]  a0_od;
    logic m0_v = 1'b0;
    logic m0_r = 1'b1;
    logic [15:0] m0_d = '0;
    tb_src #(.W(16)) s0 (.clk(clk), .rst(rst), .vprob(vp), .man_en(man), .man_valid(m0_v),
                         .man_data(m0_d), .ready(a0_ir), .valid(a0_iv), .data(a0_id));
    tb_snk k0 (.clk(clk), .rprob(rp), .man_en(man), .man_ready(m0_r), .ready(a0_or));
    stream_width_adapter #(.IN_W(16), .OUT_W(4), .ORDER(swa_pkg::ORD_LSB_FIRST)) u0 (
        .clk(clk), .rst(rst), .in_valid(a0_iv), .in_ready(a0_ir), .in_data(a0_id),
        .out_valid(a0_ov), .out_ready(a0_or), .out_data(a0_od));
    tb_scoreboard #(.IN_W(16), .OUT_W(4), .MSBF(0), .REQ("R2")) sb0 (
        .clk(clk), .rst(rst), .in_valid(a0_iv), .in_ready(a0_ir), .in_data(a0_id),
        .out_valid(a0_ov), .out_ready(a0_or), .out_data(a0_od));

    // lane 1: 4 -> 16, LSB first
    logic a1_iv, a1_ir, a1_ov, a1_or;
    logic [3:0]  a1_id;
    logic [15:0] a1_od;
    logic m1_v = 1'b0;
    logic m1_r = 1'b1;
    logic [3:0] m1_d = '0;
    tb_src #(.W(4)) s1 (.clk(clk), .rst(rst), .vprob(vp), .man_en(man), .man_valid(m1_v),
                        .man_data(m1_d), .ready(a1_ir), .valid(a1_iv), .data(a1_id));
    tb_snk k1 (.clk(clk), .rprob(rp), .man_en(man), .man_ready(m1_r), .ready(a1_or));
    stream_width_adapter #(.IN_W(4), .OUT_W(16), .ORDER(swa_pkg::ORD_LSB_FIRST)) u1 (
        .clk(clk), .rst(rst), .in_valid(a1_iv), .in_ready(a1_ir), .in_data(a1_id),
        .out_valid(a1_ov), .out_ready(a1_or), .out_data(a1_od));
    tb_scoreboard #(.IN_W(4), .OUT_W(16), .MSBF(0), .REQ("R4")) sb1 (
        .clk(clk), .rst(rst), .in_valid(a1_iv), .in_ready(a1_ir), .in_data(a1_id),
        .out_valid(a1_ov), .out_ready(a1_or), .out_data(a1_od));

    // lane 2: 16 -> 4, MSB first
    logic a2_iv, a2_ir, a2_ov, a2_or;
    logic [15:0] a2_id;
    logic [3:0]  a2_od;
    tb_src #(.W(16)) s2 (.clk(clk), .rst(rst), .vprob(vp), .man_en(1'b0), .man_valid(1'b0),
                         .man_data(16'h0), .ready(a2_ir), .valid(a2_iv), .data(a2_id));
    tb_snk k2 (.clk(clk), .rprob(rp), .man_en(1'b0), .man_ready(1'b0), .ready(a2_or));
    stream_width_adapter #(.IN_W(16), .OUT_W(4), .ORDER(swa_pkg::ORD_MSB_FIRST)) u2 (
        .clk(clk), .rst(rst), .in_valid(a2_iv), .in_ready(a2_ir), .in_data(a2_id),
        .out_valid(a2_ov), .out_ready(a2_or), .out_data(a2_od));
    tb_scoreboard #(.IN_W(16), .OUT_W(4), .MSBF(1), .REQ("R3")) sb2 (
        .clk(clk), .rst(rst), .in_valid(a2_iv), .in_ready(a2_ir), .in_data(a2_id),
        .out_valid(a2_ov), .out_ready(a2_or), .out_data(a2_od));

    // lane 3: 4 -> 16, MSB first
    logic a3_iv, a3_ir, a3_ov, a3_or;
    logic [3:0]  a3_id;
    logic [15:0] a3_od;
    tb_src #(.W(4)) s3 (.clk(clk), .rst(rst), .vprob(vp), .man_en(1'b0), .man_valid(1'b0),
                        .man_data(4'h0), .ready(a3_ir), .valid(a3_iv), .data(a3_id));
    tb_snk k3 (.clk(clk), .rprob(rp), .man_en(1'b0), .man_ready(1'b0), .ready(a3_or));
    stream_width_adapter #(.IN_W(4), .OUT_W(16), .ORDER(swa_pkg::ORD_MSB_FIRST)) u3 (
        .clk(clk), .rst(rst), .in_valid(a3_iv), .in_ready(a3_ir), .in_data(a3_id),
        .out_valid(a3_ov), .out_ready(a3_or), .out_data(a3_od));
    tb_scoreboard #(.IN_W(4), .OUT_W(16), .MSBF(1), .REQ("R3")) sb3 (
        .clk(clk), .rst(rst), .in_valid(a3_iv), .in_ready(a3_ir), .in_data(a3_id),
        .out_valid(a3_ov), .out_ready(a3_or), .out_data(a3_od));

    // lane 4: 8 -> 8 pass-through
    logic a4_iv, a4_ir, a4_ov, a4_or;
    logic [7:0] a4_id, a4_od;
    logic m4_v = 1'b0;
    logic m4_r = 1'b1;
    logic [7:0] m4_d = '0;
    tb_src #(.W(8)) s4 (.clk(clk), .rst(rst), .vprob(vp), .man_en(man), .man_valid(m4_v),
                        .man_data(m4_d), .ready(a4_ir), .valid(a4_iv), .data(a4_id));
    tb_snk k4 (.clk(clk), .rprob(rp), .man_en(man), .man_ready(m4_r), .ready(a4_or));
    stream_width_adapter #(.IN_W(8), .OUT_W(8), .ORDER(swa_pkg::ORD_LSB_FIRST)) u4 (
        .clk(clk), .rst(rst), .in_valid(a4_iv), .in_ready(a4_ir), .in_data(a4_id),
        .out_valid(a4_ov), .out_ready(a4_or), .out_data(a4_od));
    tb_scoreboard #(.IN_W(8), .OUT_W(8), .MSBF(0), .REQ("R10")) sb4 (
        .clk(clk), .rst(rst), .in_valid(a4_iv), .in_ready(a4_ir), .in_data(a4_id),
        .out_valid(a4_ov), .out_ready(a4_or), .out_data(a4_od));

    // lane 5: 32 -> 8 -> 32 round trip, MSB first
    logic a5_iv, a5_ir, a5_mv, a5_mr, a5_ov, a5_or;
    logic [31:0] a5_id, a5_od;
    logic [7:0]  a5_md;
    tb_src #(.W(32)) s5 (.clk(clk), .rst(rst), .vprob(vp), .man_en(1'b0), .man_valid(1'b0),
                         .man_data(32'h0), .ready(a5_ir), .valid(a5_iv), .data(a5_id));
    tb_snk k5 (.clk(clk), .rprob(rp), .man_en(1'b0), .man_ready(1'b0), .ready(a5_or));
    stream_width_adapter #(.IN_W(32), .OUT_W(8), .ORDER(swa_pkg::ORD_MSB_FIRST)) u5 (
        .clk(clk), .rst(rst), .in_valid(a5_iv), .in_ready(a5_ir), .in_data(a5_id),
        .out_valid(a5_mv), .out_ready(a5_mr), .out_data(a5_md));
    stream_width_adapter #(.IN_W(8), .OUT_W(32), .ORDER(swa_pkg::ORD_MSB_FIRST)) u6 (
        .clk(clk), .rst(rst), .in_valid(a5_mv), .in_ready(a5_mr), .in_data(a5_md),
        .out_valid(a5_ov), .out_ready(a5_or), .out_data(a5_od));
    tb_scoreboard #(.IN_W(32), .OUT_W(32), .MSBF(1), .REQ("R11")) sb5 (
        .clk(clk), .rst(rst), .in_valid(a5_iv), .in_ready(a5_ir), .in_data(a5_id),
        .out_valid(a5_ov), .out_ready(a5_or), .out_data(a5_od));

    // R7 gap monitor on lane 0
    bit mon0 = 0;
    int cyc = 0;
    int first_hi = -1;
    int last_hi = -1;
    int n_hi = 0;
    always @(negedge clk) begin
        cyc++;
        if (mon0 && a0_ov) begin
            if (first_hi < 0) first_hi = cyc;
            last_hi = cyc;
            n_hi++;
        end
    end

    task automatic feed0(input logic [15:0] d);
        m0_v = 1'b1;
        m0_d = d;
        @(negedge clk);
        while (!a0_ir) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic feed1(input logic [3:0] d);
        m1_v = 1'b1;
        m1_d = d;
        @(negedge clk);
        while (!a1_ir) @(negedge clk);
        @(posedge clk);
        #1;
        m1_v = 1'b0;
    endtask

    task automatic finish_run(input int extra_fail);
        int c;
        int f;
        c = tchk + sb0.nchk + sb1.nchk + sb2.nchk + sb3.nchk + sb4.nchk + sb5.nchk;
        f = tfail + sb0.nfail + sb1.nfail + sb2.nfail + sb3.nfail + sb4.nfail + sb5.nfail;
        $display("[TB] %0d tests run, %0d failed", c + extra_fail, f + extra_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R1 watchdog expired: actual hung expected finished");
        finish_run(1);
    end

    initial begin
        // reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!a0_ov, "R9", "split out_valid in reset", a0_ov, 0);
        chk(!a1_ov, "R9", "pack out_valid in reset", a1_ov, 0);
        chk(!a4_ov, "R9", "pass out_valid in reset", a4_ov, 0);
        chk(!a5_ov, "R9", "round-trip out_valid in reset", a5_ov, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;

        // R7: back-to-back split, no bubbles
        mon0 = 1;
        feed0(16'hA1B2);
        feed0(16'hC3D4);
        feed0(16'hE5F6);
        feed0(16'h0718);
        m0_v = 1'b0;
        repeat (24) @(posedge clk);
        #1;
        mon0 = 0;
        chk(n_hi == 16, "R7", "split out_valid cycles", n_hi, 16);
        chk(last_hi - first_hi + 1 == 16, "R7", "split run length without gap",
            last_hi - first_hi + 1, 16);

        // R4/R6/R1/R8: packing with held output
        m1_r = 1'b0;
        feed1(4'h1);
        feed1(4'h2);
        feed1(4'h3);
        feed1(4'h4);
        @(negedge clk);
        chk(a1_ov, "R6", "packed word valid after last sub-word", a1_ov, 1);
        chk(a1_od == 16'h4321, "R4", "LSB-first packed word", a1_od, 16'h4321);
        @(posedge clk);
        #1;
        m1_v = 1'b1;
        m1_d = 4'h5;
        @(negedge clk);
        chk(a1_ir, "R6", "first sub-word taken while output held", a1_ir, 1);
        @(posedge clk);
        #1;
        m1_v = 1'b0;
        feed1(4'h6);
        feed1(4'h7);
        m1_v = 1'b1;
        m1_d = 4'h8;
        @(negedge clk);
        chk(!a1_ir, "R1", "last sub-word stalled behind held word", a1_ir, 0);
        chk(a1_od == 16'h4321 && a1_ov, "R8", "held packed word", a1_od, 16'h4321);
        @(posedge clk);
        #1;
        @(negedge clk);
        chk(!a1_ir, "R1", "stall persists", a1_ir, 0);
        @(posedge clk);
        #1;
        m1_r = 1'b1;
        @(negedge clk);
        chk(a1_ir, "R5", "completion and output take in same cycle", a1_ir, 1);
        @(posedge clk);
        #1;
        m1_v = 1'b0;
        @(negedge clk);
        chk(a1_ov && a1_od == 16'h8765, "R6", "next packed word next cycle", a1_od, 16'h8765);
        @(posedge clk);
        #1;

        // R10: pass-through
        m4_r = 1'b0;
        m4_v = 1'b1;
        m4_d = 8'h5A;
        @(negedge clk);
        chk(a4_ir, "R10", "pass in_ready when empty", a4_ir, 1);
        @(posedge clk);
        #1;
        m4_d = 8'hC3;
        @(negedge clk);
        chk(a4_ov && a4_od == 8'h5A, "R10", "pass word one cycle later", a4_od, 8'h5A);
        chk(!a4_ir, "R1", "pass blocks while output held", a4_ir, 0);
        @(posedge clk);
        #1;
        m4_r = 1'b1;
        @(negedge clk);
        chk(a4_ir && a4_od == 8'h5A, "R10", "pass ready when output leaves", a4_ir, 1);
        @(posedge clk);
        #1;
        m4_v = 1'b0;
        @(negedge clk);
        chk(a4_ov && a4_od == 8'hC3, "R10", "pass second word", a4_od, 8'hC3);
        @(posedge clk);
        #1;

        // random traffic on all lanes
        man = 1'b0;
        vp = 100; rp = 100;
        repeat (800) @(posedge clk);
        vp = 70;  rp = 50;
        repeat (800) @(posedge clk);
        vp = 100; rp = 30;
        repeat (800) @(posedge clk);
        vp = 40;  rp = 100;
        repeat (800) @(posedge clk);
        vp = 0;   rp = 100;
        repeat (120) @(posedge clk);
        @(negedge clk);
        sb0.final_check();
        sb1.final_check();
        sb2.final_check();
        sb3.final_check();
        sb4.final_check();
        sb5.final_check();
        finish_run(0);
    end
endmodule